// File: doc/BRIEF.md
# Arithmetic Condition Code Unit

This unit runs one integer operation per cycle on two signed accumulator operands and keeps the status flags that later instructions test. These are a two-bit condition code, an overflow flag, a sticky overflow flag and a binary result flag. Operation classes are compare, add, subtract, multiply, divide, modulo, shift, rotate and word logic. The condition code carries a different meaning for each class. The overflow flag follows the most recent arithmetic operation. The sticky flag records any overflow until a jump-on-overflow, block call or block end event clears it.

An operation is presented with `opValid` high for one clock. The result word and the flags are registered on that edge and are visible after it. For arithmetic the second operand is the left-hand side, so subtract gives `opB - opA` and divide gives `opB / opA`. Shifts and rotates act on `opA` by `shiftCnt` places. The binary result flag is loaded through its own strobe and drives the enable output.

Top module: `cond_code_unit`

## Requirements
- R1: After reset `result` is 0, `statusFlags` is 0 and `eno` is 0. `statusFlags` packs {bit4 binary result, bit3 CC1, bit2 CC0, bit1 overflow, bit0 sticky overflow}, which are status-word bits 8 down to 4.
- R2: A compare (code 0) sets CC1:CC0 to 00 when opB equals opA, to 01 when opB is less than opA and to 10 when opB is greater. The signed values are compared. `result` and the overflow flag keep their values.
- R3: Add (code 1), subtract (code 2), multiply (code 3), divide (code 4, truncating toward zero) and modulo (code 5, sign of opB) write the W-bit result. When the result fits, they clear the overflow flag and set CC1:CC0 to 00 for zero, 01 for negative and 10 for positive.
- R4: An add or subtract whose true result falls outside the signed range writes the wrapped result and sets the overflow flag. CC1:CC0 becomes 10 when the true result is above the range and 01 when it is below.
- R5: A multiply whose true product does not fit writes the low W bits and sets the overflow flag. CC1:CC0 follows the rule of R4. Dividing the most negative value by -1 is a positive overflow that returns the most negative value.
- R6: A divide or modulo with opA equal to 0 writes result 0, sets CC1:CC0 to 11 and sets the overflow flag.
- R7: Shift left (code 6) and logical shift right (code 7) of opA by shiftCnt fill with zeros. CC1:CC0 becomes 10 if the last bit shifted out was 1 and 00 otherwise. A count of 0 leaves opA unchanged and gives 00.
- R8: Rotate left (code 8) and rotate right (code 9) use the same code rule. The last bit shifted out is the bit that wraps around, and a count of 0 gives 00.
- R9: AND (code 10), OR (code 11) and XOR (code 12) set CC1:CC0 to 00 for a zero result and to 10 for a nonzero result.
- R10: The sticky flag is set in any cycle that sets the overflow flag. It stays set after the overflow flag clears.
- R11: `osClr` clears the sticky flag. An overflow in the same cycle still leaves the sticky flag set.
- R12: `brLoad` copies `brIn` into the binary result flag and `eno` follows that flag. Operations never change it.
- R13: With `opValid` low, or with an unused code (13 to 15), `result`, the condition code and the overflow flag hold their values.
- R14: Compare, shift, rotate and word-logic operations leave the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| opValid | input | 1 | Execute the operation this cycle |
| opSel | input | 4 | Operation code, see requirements |
| opA | input | W | First accumulator operand (right-hand side, shift source) |
| opB | input | W | Second accumulator operand (left-hand side) |
| shiftCnt | input | SHW | Shift or rotate distance |
| osClr | input | 1 | Clear sticky overflow (jump-on-overflow, block call or block end) |
| brLoad | input | 1 | Load the binary result flag |
| brIn | input | 1 | Value for the binary result flag |
| result | output | W | Registered result word |
| statusFlags | output | 5 | {BR, CC1, CC0, OV, OS} |
| eno | output | 1 | Block enable output, equal to the binary result flag |

## Verification
The bench builds the unit with W = 16 and SHW = 4, the widths of the accumulators it models. At these widths every saturation corner can be driven directly: the 32767 and -32768 edges of add and subtract, products just outside 16 bits, the division of -32768 by -1, and every shift distance from 0 to 15. A pseudo-random stream mixes all sixteen codes with clear and save strobes. That stream covers sticky-flag interplay that directed cases miss, such as a clear arriving together with a new overflow.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [3:0] {
    OP_CMP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_MUL = 4'd3,
    OP_DIV = 4'd4,  OP_MOD = 4'd5,  OP_SHL = 4'd6,  OP_SHR = 4'd7,
    OP_ROL = 4'd8,  OP_ROR = 4'd9,  OP_AND = 4'd10, OP_OR  = 4'd11,
    OP_XOR = 4'd12
  } opCode_e;

  localparam logic [3:0] LAST_OP = 4'd12;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_CMP, CLS_ARITH, CLS_SHIFT, CLS_LOGIC
  } opClass_e;

  // control -> datapath strobes
  typedef struct packed {
    opCode_e  op;
    opClass_e cls;
    logic     ldRes;
  } dpStrobe_t;

  // datapath -> control outcome
  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf;
    logic ovfPos;
    logic divZero;
    logic outBit;
    logic cmpEq;
    logic cmpLt;
  } dpStatus_t;

endpackage

// File: rtl/ccu_datapath.sv
module ccu_datapath
  import ccu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strb,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [SHW-1:0] shiftCnt,
  output logic [W-1:0]   result,
  output dpStatus_t      stat
);
  localparam int          W2       = 2 * W;
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W:0]      sumExt, difExt;
  logic [W2-1:0]   prodFull;
  logic            prodOvf;
  logic [W-1:0]    safeDiv, quo, rem, negB;
  logic            divByZero, divByMinus1;
  logic [W2-1:0]   shlTmp, shrTmp, rolTmp, rorTmp;
  logic            shiftNz;
  logic [W-1:0]    resNext;
  logic            ovf, ovfPos, outBit;

  assign sumExt = {opB[W-1], opB} + {opA[W-1], opA};
  assign difExt = {opB[W-1], opB} - {opA[W-1], opA};

  assign prodFull = $signed({{W{opB[W-1]}}, opB}) * $signed({{W{opA[W-1]}}, opA});
  assign prodOvf  = !((&prodFull[W2-1:W-1]) || !(|prodFull[W2-1:W-1]));

  // keep the divider away from zero and the -MIN/-1 trap
  assign divByZero   = (opA == '0);
  assign divByMinus1 = (opA == ALL_ONES);
  assign safeDiv     = (divByZero || divByMinus1) ? ONE : opA;
  assign quo         = $signed(opB) / $signed(safeDiv);
  assign rem         = $signed(opB) % $signed(safeDiv);
  assign negB        = '0 - opB;

  assign shiftNz = |shiftCnt;
  assign shlTmp  = {{W{1'b0}}, opA} << shiftCnt;
  assign shrTmp  = {opA, {W{1'b0}}} >> shiftCnt;
  assign rolTmp  = {opA, opA} << shiftCnt;
  assign rorTmp  = {opA, opA} >> shiftCnt;

  always_comb begin
    resNext = opA;
    ovf     = 1'b0;
    ovfPos  = 1'b0;
    outBit  = 1'b0;
    unique case (strb.op)
      OP_ADD: begin
        resNext = sumExt[W-1:0];
        ovf     = sumExt[W] ^ sumExt[W-1];
        ovfPos  = !sumExt[W];
      end
      OP_SUB: begin
        resNext = difExt[W-1:0];
        ovf     = difExt[W] ^ difExt[W-1];
        ovfPos  = !difExt[W];
      end
      OP_MUL: begin
        resNext = prodFull[W-1:0];
        ovf     = prodOvf;
        ovfPos  = !prodFull[W2-1];
      end
      OP_DIV: begin
        if (divByZero) resNext = '0;
        else if (divByMinus1) begin
          resNext = negB;
          ovf     = (opB == {1'b1, {(W-1){1'b0}}});
          ovfPos  = 1'b1;
        end else resNext = quo;
      end
      OP_MOD: resNext = (divByZero || divByMinus1) ? '0 : rem;
      OP_SHL: begin resNext = shlTmp[W-1:0];  outBit = shiftNz && shlTmp[W];   end
      OP_SHR: begin resNext = shrTmp[W2-1:W]; outBit = shiftNz && shrTmp[W-1]; end
      OP_ROL: begin resNext = rolTmp[W2-1:W]; outBit = shiftNz && rolTmp[W];   end
      OP_ROR: begin resNext = rorTmp[W-1:0];  outBit = shiftNz && rorTmp[W-1]; end
      OP_AND: resNext = opA & opB;
      OP_OR:  resNext = opA | opB;
      OP_XOR: resNext = opA ^ opB;
      default: resNext = opA;
    endcase
  end

  assign stat.zero    = (resNext == '0);
  assign stat.neg     = resNext[W-1];
  assign stat.ovf     = ovf;
  assign stat.ovfPos  = ovfPos;
  assign stat.divZero = divByZero && (strb.op == OP_DIV || strb.op == OP_MOD);
  assign stat.outBit  = outBit;
  assign stat.cmpEq   = (opA == opB);
  assign stat.cmpLt   = $signed(opB) < $signed(opA);

  always_ff @(posedge clk) begin
    if (!rstN)          result <= '0;
    else if (strb.ldRes) result <= resNext;
  end

endmodule

// File: rtl/ccu_control.sv
module ccu_control
  import ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opSel,
  input  logic       osClr,
  input  logic       brLoad,
  input  logic       brIn,
  input  dpStatus_t  stat,
  output dpStrobe_t  strb,
  output logic [1:0] ccBits,
  output logic       ovFlag,
  output logic       osFlag,
  output logic       brFlag
);
  opClass_e   cls;
  logic [1:0] ccNext;
  logic       ovRaise;

  always_comb begin
    cls = CLS_NONE;
    if (opValid && opSel <= LAST_OP) begin
      unique case (opCode_e'(opSel))
        OP_CMP:                         cls = CLS_CMP;
        OP_ADD, OP_SUB, OP_MUL,
        OP_DIV, OP_MOD:                 cls = CLS_ARITH;
        OP_SHL, OP_SHR, OP_ROL, OP_ROR: cls = CLS_SHIFT;
        default:                        cls = CLS_LOGIC;
      endcase
    end
  end

  assign strb.op    = opCode_e'(opSel);
  assign strb.cls   = cls;
  assign strb.ldRes = (cls == CLS_ARITH) || (cls == CLS_SHIFT) || (cls == CLS_LOGIC);

  assign ovRaise = (cls == CLS_ARITH) && (stat.ovf || stat.divZero);

  always_comb begin
    ccNext = ccBits;
    unique case (cls)
      CLS_CMP:   ccNext = stat.cmpEq ? 2'b00 : (stat.cmpLt ? 2'b01 : 2'b10);
      CLS_ARITH: begin
        if (stat.divZero)   ccNext = 2'b11;
        else if (stat.ovf)  ccNext = stat.ovfPos ? 2'b10 : 2'b01;
        else if (stat.zero) ccNext = 2'b00;
        else                ccNext = stat.neg ? 2'b01 : 2'b10;
      end
      CLS_SHIFT: ccNext = stat.outBit ? 2'b10 : 2'b00;
      CLS_LOGIC: ccNext = stat.zero ? 2'b00 : 2'b10;
      default:   ccNext = ccBits;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccBits <= 2'b00;
      ovFlag <= 1'b0;
      osFlag <= 1'b0;
      brFlag <= 1'b0;
    end else begin
      ccBits <= ccNext;
      if (cls == CLS_ARITH) ovFlag <= ovRaise;
      osFlag <= (osFlag && !osClr) || ovRaise;
      if (brLoad) brFlag <= brIn;
    end
  end

endmodule

// File: rtl/cond_code_unit.sv
module cond_code_unit
  import ccu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic [3:0]     opSel,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [SHW-1:0] shiftCnt,
  input  logic           osClr,
  input  logic           brLoad,
  input  logic           brIn,
  output logic [W-1:0]   result,
  output logic [4:0]     statusFlags,
  output logic           eno
);
  dpStrobe_t  strb;
  dpStatus_t  stat;
  logic [1:0] ccBits;
  logic       ovFlag, osFlag, brFlag;

  ccu_control uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .osClr(osClr), .brLoad(brLoad), .brIn(brIn), .stat(stat),
    .strb(strb), .ccBits(ccBits), .ovFlag(ovFlag), .osFlag(osFlag),
    .brFlag(brFlag)
  );

  ccu_datapath #(.W(W), .SHW(SHW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .shiftCnt(shiftCnt), .result(result), .stat(stat)
  );

  assign statusFlags = {brFlag, ccBits, ovFlag, osFlag};
  assign eno         = brFlag;

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker
  import ccu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input logic           clk,
  input logic           rstN,
  input logic           opValid,
  input logic [3:0]     opSel,
  input logic [W-1:0]   opA,
  input logic           osClr,
  input logic           brLoad,
  input logic           brIn,
  input logic [W-1:0]   result,
  input logic [4:0]     statusFlags,
  input logic           eno
);
  logic ov, os;
  assign ov = statusFlags[1];
  assign os = statusFlags[0];

  // R2
  a_r2_cmp_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_CMP) |=> ($stable(result) && $stable(ov)));

  // R6
  a_r6_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_DIV || opSel == OP_MOD) && opA == '0)
      |=> (statusFlags[3:2] == 2'b11 && ov && result == '0));

  // R10
  a_r10_os_follows_ov: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ov) |-> os);

  a_r10_os_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (os && !osClr) |=> os);

  // R11
  a_r11_os_clear: assert property (@(posedge clk) disable iff (!rstN)
    (osClr && !opValid) |=> !os);

  // R12
  a_r12_br_load: assert property (@(posedge clk) disable iff (!rstN)
    brLoad |=> (eno == $past(brIn)));

  a_r12_br_hold: assert property (@(posedge clk) disable iff (!rstN)
    !brLoad |=> $stable(eno));

  // R13
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opSel > LAST_OP) |=> ($stable(result) && $stable(statusFlags[3:1])));

endmodule

bind cond_code_unit ccu_checker #(.W(W), .SHW(SHW)) uChk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .opA(opA),
  .osClr(osClr), .brLoad(brLoad), .brIn(brIn), .result(result),
  .statusFlags(statusFlags), .eno(eno)
);

// File: tb/tb_cond_code_unit.sv
module tb_cond_code_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opSel = '0;
  logic [15:0] opA = '0, opB = '0;
  logic [3:0]  shiftCnt = '0;
  logic        osClr = 1'b0, brLoad = 1'b0, brIn = 1'b0;
  logic [15:0] result;
  logic [4:0]  statusFlags;
  logic        eno;

  cond_code_unit #(.W(16), .SHW(4)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .opA(opA),
    .opB(opB), .shiftCnt(shiftCnt), .osClr(osClr), .brLoad(brLoad),
    .brIn(brIn), .result(result), .statusFlags(statusFlags), .eno(eno)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // reference state
  logic [15:0] mRes = '0;
  logic [1:0]  mCc = '0;
  logic        mOv = 0, mOs = 0, mBr = 0;

  // scoreboard queues: {result, br, cc1, cc0, ov, os, eno}
  logic [21:0] qVal[$];
  int          qDue[$];
  string       qReq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic [21:0] act, input logic [21:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic [3:0] sel, input logic [15:0] a,
                       input logic [15:0] b, input logic [3:0] n, input logic clr,
                       input logic ld, input logic bin);
    int ia, ib, t;
    bit dz, ovf, osSet;
    logic [15:0] r;
    logic o;
    ia = int'($signed(a));
    ib = int'($signed(b));
    osSet = 0;
    if (v && sel <= 4'd12) begin
      if (sel == 4'd0) begin
        mCc = (ib == ia) ? 2'b00 : ((ib < ia) ? 2'b01 : 2'b10);
      end else if (sel <= 4'd5) begin
        dz = 0; t = 0;
        case (sel)
          4'd1: t = ib + ia;
          4'd2: t = ib - ia;
          4'd3: t = ib * ia;
          4'd4: if (ia == 0) dz = 1; else t = ib / ia;
          default: if (ia == 0) dz = 1; else t = ib % ia;
        endcase
        ovf  = !dz && (t > 32767 || t < -32768);
        mRes = dz ? 16'h0 : t[15:0];
        if (dz)        mCc = 2'b11;
        else if (ovf)  mCc = (t > 0) ? 2'b10 : 2'b01;
        else if (t==0) mCc = 2'b00;
        else           mCc = (t < 0) ? 2'b01 : 2'b10;
        mOv   = dz || ovf;
        osSet = mOv;
      end else if (sel <= 4'd9) begin
        r = a; o = 1'b0;
        for (int i = 0; i < int'(n); i++) begin
          case (sel)
            4'd6: begin o = r[15]; r = {r[14:0], 1'b0}; end
            4'd7: begin o = r[0];  r = {1'b0, r[15:1]}; end
            4'd8: begin o = r[15]; r = {r[14:0], r[15]}; end
            default: begin o = r[0]; r = {r[0], r[15:1]}; end
          endcase
        end
        mRes = r;
        mCc  = o ? 2'b10 : 2'b00;
      end else begin
        case (sel)
          4'd10: r = a & b;
          4'd11: r = a | b;
          default: r = a ^ b;
        endcase
        mRes = r;
        mCc  = (r == 16'h0) ? 2'b00 : 2'b10;
      end
    end
    mOs = (mOs && !clr) || osSet;
    if (ld) mBr = bin;
  endtask

  task automatic drive(input logic v, input logic [3:0] sel, input logic [15:0] a,
                       input logic [15:0] b, input logic [3:0] n, input logic clr,
                       input logic ld, input logic bin, input string req);
    @(negedge clk);
    opValid = v; opSel = sel; opA = a; opB = b; shiftCnt = n;
    osClr = clr; brLoad = ld; brIn = bin;
    model(v, sel, a, b, n, clr, ld, bin);
    qVal.push_back({mRes, mBr, mCc, mOv, mOs, mBr});
    qDue.push_back(cyc + 1);
    qReq.push_back(req);
  endtask

  task automatic op(input logic [3:0] sel, input logic [15:0] a, input logic [15:0] b,
                    input string req);
    drive(1'b1, sel, a, b, 4'd0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic sh(input logic [3:0] sel, input logic [15:0] a, input logic [3:0] n,
                    input string req);
    drive(1'b1, sel, a, 16'h0, n, 1'b0, 1'b0, 1'b0, req);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (qDue.size() > 0 && qDue[0] <= cyc) begin
        check({result, statusFlags, eno}, qVal[0], qReq[0]);
        void'(qVal.pop_front());
        void'(qDue.pop_front());
        void'(qReq.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [15:0] pick [8];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check({result, statusFlags, eno}, 22'h0, "R1 reset state");

    // R2 compare
    op(4'd0, 16'd5, 16'd5, "R2 cmp equal");
    op(4'd0, 16'd2, 16'hFFFD, "R2 cmp less");
    op(4'd0, 16'hFFFF, 16'd7, "R2 cmp greater");
    // R3 in range
    op(4'd1, 16'd23, 16'd100, "R3 add positive");
    op(4'd1, 16'd5, 16'hFFFB, "R3 add zero");
    op(4'd2, 16'd10, 16'd3, "R3 sub negative");
    // R4 add/sub overflow, R10 sticky, R14 hold
    op(4'd1, 16'd1, 16'h7FFF, "R4 add positive overflow");
    op(4'd0, 16'd1, 16'd1, "R14 cmp keeps OV");
    sh(4'd6, 16'h0001, 4'd1, "R14 shift keeps OV");
    op(4'd10, 16'h00FF, 16'h0F0F, "R14 logic keeps OV");
    op(4'd1, 16'd1, 16'd1, "R10 OV clears OS stays");
    op(4'd2, 16'd1, 16'h8000, "R4 sub negative overflow");
    // R11
    drive(1'b0, 4'd0, 16'h0, 16'h0, 4'd0, 1'b1, 1'b0, 1'b0, "R11 clear OS");
    drive(1'b1, 4'd1, 16'h7FFF, 16'h7FFF, 4'd0, 1'b1, 1'b0, 1'b0, "R11 clear with overflow");
    drive(1'b1, 4'd1, 16'd2, 16'd2, 4'd0, 1'b1, 1'b0, 1'b0, "R11 clear with clean add");
    // R5 multiply
    op(4'd3, 16'd200, 16'd300, "R5 mul positive overflow");
    op(4'd3, 16'd200, 16'hFED4, "R5 mul negative overflow");
    op(4'd3, 16'd6, 16'hFFF9, "R3 mul in range");
    // divide / modulo
    op(4'd4, 16'd7, 16'd100, "R3 div positive");
    op(4'd4, 16'd7, 16'hFF9C, "R3 div truncates toward zero");
    op(4'd5, 16'd7, 16'hFF9C, "R3 mod sign of dividend");
    op(4'd4, 16'h0, 16'd55, "R6 div by zero");
    op(4'd1, 16'd1, 16'd1, "R3 add clears OV");
    op(4'd5, 16'h0, 16'h8000, "R6 mod by zero");
    op(4'd4, 16'hFFFF, 16'h8000, "R5 min div minus one");
    op(4'd5, 16'hFFFF, 16'h8000, "R3 min mod minus one");
    // R7 shifts
    sh(4'd6, 16'h8001, 4'd1, "R7 shl out one");
    sh(4'd6, 16'h1234, 4'd0, "R7 shl count zero");
    sh(4'd7, 16'h0004, 4'd2, "R7 shr out zero");
    sh(4'd7, 16'h000C, 4'd3, "R7 shr out one");
    sh(4'd6, 16'h0001, 4'd15, "R7 shl max count");
    // R8 rotates
    sh(4'd8, 16'h8000, 4'd1, "R8 rol wrap one");
    sh(4'd9, 16'h0002, 4'd1, "R8 ror out zero");
    sh(4'd9, 16'h0001, 4'd15, "R8 ror max count");
    sh(4'd8, 16'hABCD, 4'd0, "R8 rol count zero");
    // R9 word logic
    op(4'd10, 16'h0F0F, 16'hF0F0, "R9 and zero");
    op(4'd11, 16'h0F0F, 16'hF0F0, "R9 or nonzero");
    op(4'd12, 16'h5A5A, 16'h5A5A, "R9 xor zero");
    // R12 binary result
    drive(1'b0, 4'd0, 16'h0, 16'h0, 4'd0, 1'b0, 1'b1, 1'b1, "R12 load one");
    op(4'd1, 16'h7FFF, 16'h7FFF, "R12 op keeps BR");
    drive(1'b1, 4'd11, 16'h1, 16'h0, 4'd0, 1'b0, 1'b1, 1'b0, "R12 load zero with op");
    // R13
    drive(1'b0, 4'd1, 16'h1111, 16'h2222, 4'd3, 1'b0, 1'b0, 1'b0, "R13 idle holds");
    op(4'd13, 16'h1111, 16'h2222, "R13 unused code 13");
    op(4'd15, 16'h0, 16'h0, "R13 unused code 15");

    // mixed stream
    seed = 32'h1357_9BDF;
    pick[0] = 16'h0000; pick[1] = 16'hFFFF; pick[2] = 16'h7FFF; pick[3] = 16'h8000;
    pick[4] = 16'h0001; pick[5] = 16'h00B4; pick[6] = 16'hFF38; pick[7] = 16'h4000;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ra, rb;
      seed = seed * 32'd1103515245 + 32'd12345;
      ra = seed[20] ? pick[seed[23:21]] : seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345;
      rb = seed[20] ? pick[seed[23:21]] : seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345;
      drive(seed[30:28] != 3'd0, seed[19:16], ra, rb, seed[27:24],
            seed[15:13] == 3'd0, seed[12:10] == 3'd0, seed[9],
            "R3 R10 R11 R12 mixed stream");
    end
    drive(1'b0, 4'd0, 16'h0, 16'h0, 4'd0, 1'b0, 1'b0, 1'b0, "R13 final idle");

    while (qDue.size() > 0) @(negedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule